// File: doc/BRIEF.md
# Wide-to-Narrow Memory Width Adapter

This block sits between a 32-bit memory-mapped master and a 16-bit memory-mapped slave. The master issues byte addresses aligned to its own width, together with a 4-bit byte mask. The slave takes 16-bit word addresses and a 2-bit byte mask. Each master read or write is split into one or two slave accesses. There is one access for each 16-bit half of the master word that has at least one mask bit set. The halves are issued in ascending order, and each access carries its own slice of the mask and write data.

Both sides use read and write strobes with a waitrequest stall and a readdatavalid return strobe. The master is held on waitrequest until every slave access of its transaction has been accepted. For reads, the adapter gathers the returned 16-bit words into their lanes of the 32-bit response. It then gives the master one readdatavalid pulse. Only one slave read is ever outstanding.

Top module: `mem_width_bridge`

## Requirements
- R1: The slave word address of an access equals the master byte address shifted right by one bit, plus the half index (0 for mask bits 1:0, 1 for mask bits 3:2).
- R2: A master access with all four mask bits set produces exactly two slave accesses of the same kind, lower half first, then upper half.
- R3: A master mask of 1100 at byte address A produces a single slave access at word A/2+1 with slave mask 11. A master mask of 0011 produces a single access at word A/2 with slave mask 11.
- R4: A half whose two mask bits are both zero produces no slave access. A master access with mask 0000 produces no slave access at all. A write with mask 0000 leaves memory unchanged, and a read with mask 0000 returns zero.
- R5: For a write, each slave access carries bits [16h+15:16h] of the master write data, and its 2-bit slave mask equals master mask bits [2h+1:2h].
- R6: For a read, the slave word for half h appears in bits [16h+15:16h] of the master read data. A half that was not read returns zero.
- R7: For each master read, exactly one master readdatavalid pulse is given, and only after the last slave read of that transaction has returned its data.
- R8: Master waitrequest stays high until every slave access of the current transaction has been accepted. It is then low for exactly one cycle. While slave waitrequest is high, the slave command, address, mask and data stay unchanged.
- R9: A synchronous active-low reset returns the block to idle. Slave strobes are low and master waitrequest is high, and a partly completed transaction is dropped without any later slave access.
- R10: At most one slave read is outstanding. No new slave read is presented until the data of the previous one has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_address | input | 32 | Master byte address, 4-byte aligned |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_byteenable | input | 4 | Master byte mask |
| m_writedata | input | 32 | Master write data |
| m_waitrequest | output | 1 | Stall to master; low for the accepting cycle |
| m_readdata | output | 32 | Assembled read data |
| m_readdatavalid | output | 1 | Read data valid pulse |
| s_address | output | 31 | Slave 16-bit word address |
| s_read | output | 1 | Slave read strobe |
| s_write | output | 1 | Slave write strobe |
| s_byteenable | output | 2 | Slave byte mask |
| s_writedata | output | 16 | Slave write data |
| s_waitrequest | input | 1 | Slave stall |
| s_readdata | input | 16 | Slave read data |
| s_readdatavalid | input | 1 | Slave read data valid |

## Verification
The bench sweeps all sixteen master masks, under slave stalls and under read latencies of several cycles. This exposes designs that issue an access for an empty half, and designs that drop the upper half or swap the order of the halves. Single-byte writes check mask remapping: a design that forces both slave enables high would overwrite the neighbouring byte, and a later full read would show it. Reads with half masks check that unread lanes come back zero rather than stale data from an earlier read. A reset during a stalled write checks that the aborted transaction never reaches memory.

// File: rtl/wnb_pkg.sv
// Shared types for the wide-to-narrow width adapter.
// Assumes nothing beyond a single clock domain.
package wnb_pkg;
    // Sequencer states of the adapter
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a master request
        ST_ISSUE,   // presenting a slave access for the current half
        ST_RDWAIT,  // waiting for the slave read data of that half
        ST_ACK,     // releasing master waitrequest for one cycle
        ST_RESP     // pulsing master readdatavalid after a read
    } wnb_state_e;
endpackage

// File: rtl/wnb_lane_pick.sv
// Picks the lowest pending half of a wide access and returns the pending
// set with that half removed. Purely combinational.
// Assumes IW is wide enough to index LANES halves.
module wnb_lane_pick #(
    parameter int LANES = 2,
    parameter int IW    = 1
) (
    input  logic [LANES-1:0] pend,
    output logic [IW-1:0]    idx,
    output logic [LANES-1:0] rest
);
    // Lowest-set-bit priority search over the pending halves
    always_comb begin
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
        rest = pend & ~(LANES'(1) << idx);
    end
endmodule

// File: rtl/wnb_slv_cmd.sv
// Forms the narrow slave address, mask and write data for one half of the
// captured wide access. Combinational.
// Assumes base is the wide byte address already converted to narrow words.
module wnb_slv_cmd #(
    parameter int LANES = 2,
    parameter int LW    = 16,
    parameter int SBW   = 2,
    parameter int SAW   = 31,
    parameter int IW    = 1,
    localparam int MBW  = LANES * SBW,
    localparam int MDW  = LANES * LW
) (
    input  logic [SAW-1:0] base,
    input  logic [IW-1:0]  idx,
    input  logic [MBW-1:0] mask,
    input  logic [MDW-1:0] wdata,
    output logic [SAW-1:0] s_addr,
    output logic [SBW-1:0] s_be,
    output logic [LW-1:0]  s_wd
);
    // Slice the captured mask and data by the selected half
    always_comb begin
        s_addr = base + SAW'(idx);
        s_be   = mask[idx*SBW +: SBW];
        s_wd   = wdata[idx*LW +: LW];
    end
endmodule

// File: rtl/wnb_rd_merge.sv
// Holds one narrow word per half of the wide read response. All lanes
// clear at the start of a transaction, so lanes never read stay zero.
// Assumes at most one load per cycle.
module wnb_rd_merge #(
    parameter int LANES = 2,
    parameter int LW    = 16,
    parameter int IW    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [IW-1:0]    idx,
    input  logic [LW-1:0]    word,
    output logic [LANES*LW-1:0] data
);
    logic [LW-1:0] lane_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Capture the returned narrow word into its own lane
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lane_q[g] <= '0;
            end else if (load && (idx == IW'(g))) begin
                lane_q[g] <= word;
            end
        end
        assign data[g*LW +: LW] = lane_q[g];
    end
endmodule

// File: rtl/mem_width_bridge.sv
// Wide-to-narrow memory width adapter. Splits each wide master access into
// one narrow slave access per active half, in ascending order, and merges
// narrow read data into one wide response.
// Assumes: master addresses are aligned to M_DW/8 bytes, read and write are
// not requested together (read wins), and the master holds its request
// while waitrequest is high.
module mem_width_bridge
    import wnb_pkg::*;
#(
    parameter int M_DW  = 32,
    parameter int S_DW  = 16,
    parameter int M_AW  = 32,
    localparam int M_BEW = M_DW / 8,
    localparam int S_BEW = S_DW / 8,
    localparam int S_AW  = M_AW - $clog2(S_BEW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [M_AW-1:0]  m_address,
    input  logic             m_read,
    input  logic             m_write,
    input  logic [M_BEW-1:0] m_byteenable,
    input  logic [M_DW-1:0]  m_writedata,
    output logic             m_waitrequest,
    output logic [M_DW-1:0]  m_readdata,
    output logic             m_readdatavalid,
    output logic [S_AW-1:0]  s_address,
    output logic             s_read,
    output logic             s_write,
    output logic [S_BEW-1:0] s_byteenable,
    output logic [S_DW-1:0]  s_writedata,
    input  logic             s_waitrequest,
    input  logic [S_DW-1:0]  s_readdata,
    input  logic             s_readdatavalid
);
    localparam int LANES = M_DW / S_DW;
    localparam int SHIFT = $clog2(S_BEW);
    localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1;

    wnb_state_e       st_q;
    logic             op_rd_q;
    logic [S_AW-1:0]  base_q;
    logic [M_BEW-1:0] mask_q;
    logic [M_DW-1:0]  wdata_q;
    logic [LANES-1:0] pend_q;

    logic [LANES-1:0] half_act;
    logic [IW-1:0]    lane_idx;
    logic [LANES-1:0] pend_rest;
    logic             req;
    logic             mrg_clr;
    logic             mrg_load;

    assign req = m_read || m_write;

    for (genvar g = 0; g < LANES; g++) begin : g_act
        assign half_act[g] = |m_byteenable[g*S_BEW +: S_BEW];
    end

    wnb_lane_pick #(.LANES(LANES), .IW(IW)) pick_i (
        .pend (pend_q),
        .idx  (lane_idx),
        .rest (pend_rest)
    );

    wnb_slv_cmd #(
        .LANES(LANES), .LW(S_DW), .SBW(S_BEW), .SAW(S_AW), .IW(IW)
    ) cmd_i (
        .base   (base_q),
        .idx    (lane_idx),
        .mask   (mask_q),
        .wdata  (wdata_q),
        .s_addr (s_address),
        .s_be   (s_byteenable),
        .s_wd   (s_writedata)
    );

    assign mrg_clr  = (st_q == ST_IDLE) && req;
    assign mrg_load = (st_q == ST_RDWAIT) && s_readdatavalid;

    wnb_rd_merge #(.LANES(LANES), .LW(S_DW), .IW(IW)) merge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mrg_clr),
        .load  (mrg_load),
        .idx   (lane_idx),
        .word  (s_readdata),
        .data  (m_readdata)
    );

    // Capture the master request when a new transaction starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_rd_q <= 1'b0;
            base_q  <= '0;
            mask_q  <= '0;
            wdata_q <= '0;
        end else if (st_q == ST_IDLE && req) begin
            op_rd_q <= m_read;
            base_q  <= m_address[M_AW-1:SHIFT];
            mask_q  <= m_byteenable;
            wdata_q <= m_writedata;
        end
    end

    // Sequence the halves: issue, wait for read data, acknowledge, respond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pend_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req) begin
                        pend_q <= half_act;
                        st_q   <= (|half_act) ? ST_ISSUE : ST_ACK;
                    end
                end
                ST_ISSUE: begin
                    if (!s_waitrequest) begin
                        if (op_rd_q) begin
                            st_q <= ST_RDWAIT;
                        end else begin
                            pend_q <= pend_rest;
                            st_q   <= (|pend_rest) ? ST_ISSUE : ST_ACK;
                        end
                    end
                end
                ST_RDWAIT: begin
                    if (s_readdatavalid) begin
                        pend_q <= pend_rest;
                        st_q   <= (|pend_rest) ? ST_ISSUE : ST_ACK;
                    end
                end
                ST_ACK:  st_q <= op_rd_q ? ST_RESP : ST_IDLE;
                ST_RESP: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the handshake outputs from the sequencer state
    always_comb begin
        m_waitrequest   = (st_q != ST_ACK);
        m_readdatavalid = (st_q == ST_RESP);
        s_read          = (st_q == ST_ISSUE) && op_rd_q;
        s_write         = (st_q == ST_ISSUE) && !op_rd_q;
    end

    // R1
    req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ((m_address & M_AW'(M_BEW - 1)) == '0));

    // R8
    slv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_read || s_write) && s_waitrequest) |=>
            (s_read == $past(s_read)) && (s_write == $past(s_write)) &&
            $stable(s_address) && $stable(s_byteenable) && $stable(s_writedata));

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m_waitrequest |=> m_waitrequest);

    // R10
    one_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_read && !s_waitrequest) |=> !s_read);

    // R7
    single_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_readdatavalid |=> !m_readdatavalid);

    // R4
    no_empty_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_write |-> (s_byteenable != '0));
endmodule

// File: tb/mem_width_bridge_tb_top.sv
module mem_width_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int M_AW = 32;
    localparam int S_AW = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] m_address = '0;
    logic        m_read = 1'b0;
    logic        m_write = 1'b0;
    logic [3:0]  m_byteenable = '0;
    logic [31:0] m_writedata = '0;
    logic        m_waitrequest;
    logic [31:0] m_readdata;
    logic        m_readdatavalid;
    logic [S_AW-1:0] s_address;
    logic        s_read, s_write;
    logic [1:0]  s_byteenable;
    logic [15:0] s_writedata;
    logic        s_waitrequest = 1'b1;
    logic [15:0] s_readdata = '0;
    logic        s_readdatavalid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_width_bridge #(.M_DW(32), .S_DW(16), .M_AW(M_AW)) dut_i (.*);

    typedef struct packed {
        logic            we;
        logic [S_AW-1:0] addr;
        logic [1:0]      be;
        logic [15:0]     wd;
    } slv_item_t;

    slv_item_t   exp_slv[$];
    logic [31:0] exp_rd[$];
    logic [15:0] ref_mem [64];
    logic [15:0] slv_mem [64];
    int errors = 0;
    int checks = 0;
    int wait_tgt = 0;
    int rd_lat = 0;
    bit rd_busy = 0;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Slave model: stalls, accepts, stores and returns data; scoreboard monitor
    initial begin
        int wcnt = 0;
        int rcnt = 0;
        logic [15:0] rdat = '0;
        slv_item_t e;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rd_busy = 0; wcnt = 0;
                s_waitrequest = 1'b1; s_readdatavalid = 1'b0;
                continue;
            end
            s_readdatavalid = 1'b0;
            if (rd_busy) begin
                if (rcnt == 0) begin
                    s_readdatavalid = 1'b1; s_readdata = rdat; rd_busy = 0;
                end else rcnt--;
            end
            if (rd_busy && s_read)
                chk(1'b0, "R10", "read issued while one outstanding", 32'(s_read), 32'h0);
            if ((s_read || s_write) && !rd_busy) begin
                if (wcnt < wait_tgt) begin
                    s_waitrequest = 1'b1; wcnt++;
                end else begin
                    s_waitrequest = 1'b0; wcnt = 0;
                    if (exp_slv.size() == 0) begin
                        chk(1'b0, "R4", "unexpected slave access", 32'(s_address), 32'h0);
                    end else begin
                        e = exp_slv.pop_front();
                        chk(s_write == e.we, "R2", "access kind", 32'(s_write), 32'(e.we));
                        chk(s_address == e.addr, "R1", "slave word address", 32'(s_address), 32'(e.addr));
                        chk(s_byteenable == e.be, "R3", "slave mask", 32'(s_byteenable), 32'(e.be));
                        if (e.we)
                            chk(s_writedata == e.wd, "R5", "slave write data", 32'(s_writedata), 32'(e.wd));
                    end
                    if (s_write) begin
                        if (s_byteenable[0]) slv_mem[s_address[5:0]][7:0]  = s_writedata[7:0];
                        if (s_byteenable[1]) slv_mem[s_address[5:0]][15:8] = s_writedata[15:8];
                    end else begin
                        rd_busy = 1; rcnt = rd_lat; rdat = slv_mem[s_address[5:0]];
                    end
                end
            end else begin
                s_waitrequest = 1'b1;
            end
        end
    end

    // Read response monitor: pops the expected wide word on each valid
    initial begin
        logic [31:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && m_readdatavalid) begin
                chk(!rd_busy && exp_slv.size() == 0, "R7", "valid before last slave read",
                    32'(exp_slv.size()), 32'h0);
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R7", "extra readdatavalid", m_readdata, 32'h0);
                end else begin
                    e = exp_rd.pop_front();
                    chk(m_readdata == e, "R6", "assembled read data", m_readdata, e);
                end
            end
        end
    end

    // Driver: predicts slave accesses and the response, then runs the handshake
    task automatic access(bit rd, logic [31:0] addr, logic [3:0] be, logic [31:0] wd);
        logic [31:0] rexp = '0;
        int w = int'(addr >> 1);
        for (int h = 0; h < 2; h++) begin
            logic [1:0] hb = be[2*h +: 2];
            if (hb != 2'b00) begin
                exp_slv.push_back('{we: !rd, addr: S_AW'(w + h), be: hb, wd: wd[16*h +: 16]});
                if (rd) rexp[16*h +: 16] = ref_mem[(w + h) % 64];
                else begin
                    if (hb[0]) ref_mem[(w + h) % 64][7:0]  = wd[16*h +: 8];
                    if (hb[1]) ref_mem[(w + h) % 64][15:8] = wd[16*h+8 +: 8];
                end
            end
        end
        if (rd) exp_rd.push_back(rexp);
        @(negedge clk);
        m_address = addr; m_read = rd; m_write = !rd; m_byteenable = be; m_writedata = wd;
        do @(negedge clk); while (m_waitrequest);
        chk(exp_slv.size() == 0, "R8", "waitrequest low with accesses pending",
            32'(exp_slv.size()), 32'h0);
        @(negedge clk);
        m_read = 1'b0; m_write = 1'b0;
        while (exp_rd.size() != 0) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run hung, actual=expired expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            ref_mem[i] = 16'h1000 + 16'(i) * 16'h0111;
            slv_mem[i] = ref_mem[i];
        end
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(m_waitrequest == 1'b1, "R9", "waitrequest in reset", 32'(m_waitrequest), 32'h1);
        chk(!s_read && !s_write, "R9", "slave strobes in reset", 32'({s_read, s_write}), 32'h0);
        chk(m_readdatavalid == 1'b0, "R9", "rvalid in reset", 32'(m_readdatavalid), 32'h0);
        rst_n = 1'b1;

        // R2 / R5: full writes and reads
        access(0, 32'd8, 4'hF, 32'hDEAD_BEEF);
        access(1, 32'd8, 4'hF, '0);
        // R3: single half masks
        access(0, 32'd0, 4'b1100, 32'hCAFE_0000);
        access(0, 32'd4, 4'b0011, 32'h0000_1234);
        access(1, 32'd0, 4'hF, '0);
        access(1, 32'd4, 4'hF, '0);
        // R5: single byte keeps neighbour byte
        access(0, 32'd12, 4'b0100, 32'h00AB_0000);
        access(1, 32'd12, 4'hF, '0);
        // R4: empty mask write and read
        access(0, 32'd16, 4'b0000, 32'hFFFF_FFFF);
        access(1, 32'd16, 4'b0000, '0);
        access(1, 32'd16, 4'hF, '0);
        // R6: unread lanes return zero
        access(1, 32'd0, 4'b1100, '0);
        access(1, 32'd4, 4'b0011, '0);

        // R8 / R10: stalls and read latency across every mask
        wait_tgt = 2; rd_lat = 3;
        for (int m = 0; m < 16; m++) begin
            access(0, 32'(32 + 4*m), 4'(m), 32'h5A00_00A5 ^ 32'(m * 32'h0101_0101));
            access(1, 32'(32 + 4*m), 4'hF, '0);
            access(1, 32'(32 + 4*m), 4'(m), '0);
        end
        wait_tgt = 1; rd_lat = 0;
        access(0, 32'd20, 4'b1001, 32'h7788_99AA);
        access(1, 32'd20, 4'hF, '0);

        // R9: reset during a stalled write drops it
        wait_tgt = 20;
        @(negedge clk);
        m_address = 32'd100; m_write = 1'b1; m_byteenable = 4'hF; m_writedata = 32'h1111_2222;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!s_write && m_waitrequest, "R9", "state after mid-transaction reset",
            32'({s_write, m_waitrequest}), 32'h1);
        m_write = 1'b0;
        exp_slv.delete();
        @(negedge clk);
        rst_n = 1'b1;
        wait_tgt = 0;
        access(1, 32'd100, 4'hF, '0);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule